// File: doc/BRIEF.md
# Reset Configuration EEPROM Loader

This block fetches the chip's two reset configuration words from a serial EEPROM while the system hard reset is held. It acts as a two-wire bus master on its own. It addresses the memory at one fixed device address, sets the memory offset to zero, and reads eight bytes in sequence. It then latches them as a low word and a high word and raises a done flag. From that point until the hard reset is released, it keeps the regular two-wire controller in reset. Once the reset is released, a single bit of the latched high word decides whether the boot sequencer is allowed to run.

The memory may fail to acknowledge. In that case the loader stops and tries again, up to a fixed number of times. If every try fails, it latches a pair of built-in default words. The built-in high word leaves boot sequencing off. If the hard reset is released before the words are latched, the loader abandons the transfer and latches the defaults. The bus clock comes from a fixed divider of the system clock. The bus lines are open-drain: an output enable of 1 pulls a line low.

Top module: `cfg_word_loader`

## Requirements
- R1: After rst_ni, done_o is 0, cfg_lo_o and cfg_hi_o show the defaults (DEF_LO, DEF_HI), boot_en_o and i2c_hold_o are 0, and neither bus line is pulled low.
- R2: No bus activity takes place while hreset_ni is high (hard reset not asserted).
- R3: A load issues the following, in order: START; the device address (DEV_ADDR, default 7'h50) with R/W=0; two offset bytes 8'h00; a repeated START; the device address with R/W=1; eight data bytes read, each acknowledged except the eighth, which gets a NACK; then STOP.
- R4: The first four bytes read form cfg_lo_o, and the last four form cfg_hi_o, each with the first byte in bits 31:24.
- R5: done_o rises with the latch. While done_o stays high, both words hold steady and the bus is released.
- R6: A NACK on any written byte ends the attempt with STOP and starts a new attempt. After MAX_RETRY (default 3) retries, the next NACK makes the loader latch DEF_LO and DEF_HI.
- R7: i2c_hold_o is 1 while the hard reset is asserted, including after the latch. It falls within 3 cycles of hreset_ni rising.
- R8: boot_en_o equals bit BOOT_BIT (default 5) of cfg_hi_o once hreset_ni has risen after a latch. At all other times it is 0.
- R9: The default high word has bit BOOT_BIT clear, so a load that falls back to the defaults leaves boot_en_o at 0.
- R10: If hreset_ni rises before the latch, the loader releases the bus, latches the defaults and raises done_o within 4 cycles.
- R11: When the hard reset is asserted again, done_o clears and a fresh load runs.
- R12: Each SCL high phase within a transfer lasts 2*CLK_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low logic reset |
| hreset_ni | input | 1 | System hard reset, active low |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| cfg_lo_o | output | WORD_W | Latched low configuration word |
| cfg_hi_o | output | WORD_W | Latched high configuration word |
| done_o | output | 1 | Words latched |
| i2c_hold_o | output | 1 | Holds the two-wire controller in reset |
| boot_en_o | output | 1 | Boot sequencer enable |

## Verification
The bench runs loads against a bus memory model. The model is filled with random bytes and set to refuse a chosen number of address bytes: zero, the retry limit, one past the limit, and random counts. This separates a clean read, the last successful retry, and the fall back to defaults. Counts of address bytes and sent bytes, together with the master's final acknowledge, confirm the transaction order. Loads with the boot bit forced both set and clear show that the enable follows the latched field and not a constant. A release in the middle of a transfer and a quiet start with the reset never asserted cover the abort and idle paths.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
  typedef enum logic [1:0] {BC_START, BC_STOP, BC_WBIT, BC_RBIT} bitcmd_e;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_WBIT, ST_WACK, ST_RSTART,
    ST_RBIT, ST_RACK, ST_STOP, ST_HOLD, ST_RUN
  } ldst_e;
endpackage

// File: rtl/cwl_sync.sv
module cwl_sync #(
  parameter int unsigned     W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/cwl_tick.sv
module cwl_tick #(
  parameter int unsigned DIV = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(DIV + 1);
  logic [CW-1:0] cnt_q;
  assign tick_o = en_i && (cnt_q == CW'(DIV - 1));
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cwl_bit_engine.sv
module cwl_bit_engine
  import cwl_pkg::*;
#(
  parameter int unsigned DIV = 125
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    flush_i,
  input  logic    go_i,
  input  bitcmd_e cmd_i,
  input  logic    bit_i,
  input  logic    sda_i,
  output logic    busy_o,
  output logic    done_o,
  output logic    bit_o,
  output logic    scl_low_o,
  output logic    sda_low_o
);
  logic       tick;
  logic [1:0] ph_q;
  logic [1:0] drv_q;
  bitcmd_e    cmd_q;
  logic       b_q;

  cwl_tick #(.DIV(DIV)) u_tick (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(busy_o), .tick_o(tick)
  );

  // {scl_low, sda_low} for a command in a quarter-period phase
  function automatic logic [1:0] drive_of(bitcmd_e c, logic [1:0] ph, logic b);
    logic edge_ph;
    edge_ph = (ph == 2'd0) || (ph == 2'd3);
    case (c)
      BC_START: case (ph)
                  2'd0:    drive_of = 2'b10;
                  2'd1:    drive_of = 2'b00;
                  2'd2:    drive_of = 2'b01;
                  default: drive_of = 2'b11;
                endcase
      BC_STOP:  case (ph)
                  2'd0:    drive_of = 2'b11;
                  2'd1:    drive_of = 2'b01;
                  default: drive_of = 2'b00;
                endcase
      BC_WBIT:  drive_of = {edge_ph, ~b};
      default:  drive_of = {edge_ph, 1'b0};
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0; done_o <= 1'b0; bit_o <= 1'b0;
      ph_q <= '0; drv_q <= '0; cmd_q <= BC_STOP; b_q <= 1'b0;
    end else if (flush_i) begin
      busy_o <= 1'b0; done_o <= 1'b0; drv_q <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o && go_i) begin
        busy_o <= 1'b1;
        cmd_q  <= cmd_i;
        b_q    <= bit_i;
        ph_q   <= 2'd0;
        drv_q  <= drive_of(cmd_i, 2'd0, bit_i);
      end else if (busy_o && tick) begin
        if (ph_q == 2'd2) bit_o <= sda_i;  // end of SCL high
        if (ph_q == 2'd3) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          ph_q  <= ph_q + 2'd1;
          drv_q <= drive_of(cmd_q, ph_q + 2'd1, b_q);
        end
      end
    end
  end

  assign scl_low_o = drv_q[1];
  assign sda_low_o = drv_q[0];
endmodule

// File: rtl/cfg_word_loader.sv
module cfg_word_loader
  import cwl_pkg::*;
#(
  parameter int unsigned   WORD_W    = 32,
  parameter logic [6:0]    DEV_ADDR  = 7'h50,
  parameter logic [31:0]   DEF_LO    = 32'h0000_A0E1,
  parameter logic [31:0]   DEF_HI    = 32'h4C00_0010,
  parameter int unsigned   BOOT_BIT  = 5,
  parameter int unsigned   CLK_DIV   = 125,
  parameter int unsigned   MAX_RETRY = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hreset_ni,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic [WORD_W-1:0] cfg_lo_o,
  output logic [WORD_W-1:0] cfg_hi_o,
  output logic              done_o,
  output logic              i2c_hold_o,
  output logic              boot_en_o
);
  localparam int unsigned RD_BYTES = 2 * WORD_W / 8;
  localparam int unsigned BI_W     = $clog2(RD_BYTES);
  localparam int unsigned TRY_W    = $clog2(MAX_RETRY + 1);

  logic hrel_s, sda_s;
  cwl_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({hreset_ni, sda_i}), .q_o({hrel_s, sda_s})
  );

  ldst_e                 st_q;
  logic                  issued_q, nack_q, done_q;
  logic [2:0]            bit_cnt_q;
  logic [BI_W-1:0]       byte_q;
  logic [TRY_W-1:0]      tries_q;
  logic [2*WORD_W-1:0]   shift_q;
  logic [WORD_W-1:0]     lo_q, hi_q;

  logic    active, abort, go, eng_busy, eng_done, eng_bit, eng_wbit, last_rd;
  bitcmd_e eng_cmd;
  logic [7:0] tx_byte;

  assign active  = (st_q != ST_IDLE) && (st_q != ST_HOLD) && (st_q != ST_RUN);
  assign abort   = active && hrel_s;
  assign go      = active && !issued_q && !eng_busy;
  assign last_rd = (byte_q == BI_W'(RD_BYTES - 1));

  always_comb begin
    case (byte_q)
      BI_W'(0): tx_byte = {DEV_ADDR, 1'b0};
      BI_W'(3): tx_byte = {DEV_ADDR, 1'b1};
      default:  tx_byte = 8'h00;  // offset 0
    endcase
  end

  always_comb begin
    eng_wbit = 1'b1;
    case (st_q)
      ST_START, ST_RSTART: eng_cmd = BC_START;
      ST_WBIT:  begin eng_cmd = BC_WBIT; eng_wbit = tx_byte[3'd7 - bit_cnt_q]; end
      ST_RACK:  begin eng_cmd = BC_WBIT; eng_wbit = last_rd; end
      ST_STOP:  eng_cmd = BC_STOP;
      default:  eng_cmd = BC_RBIT;
    endcase
  end

  cwl_bit_engine #(.DIV(CLK_DIV)) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(abort), .go_i(go),
    .cmd_i(eng_cmd), .bit_i(eng_wbit), .sda_i(sda_s),
    .busy_o(eng_busy), .done_o(eng_done), .bit_o(eng_bit),
    .scl_low_o(scl_oe_o), .sda_low_o(sda_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; issued_q <= 1'b0; nack_q <= 1'b0; done_q <= 1'b0;
      bit_cnt_q <= '0; byte_q <= '0; tries_q <= '0; shift_q <= '0;
      lo_q <= DEF_LO; hi_q <= DEF_HI;
    end else if (abort) begin
      st_q <= ST_RUN; issued_q <= 1'b0; done_q <= 1'b1;
      lo_q <= DEF_LO; hi_q <= DEF_HI;
    end else begin
      if (go) issued_q <= 1'b1;
      if (eng_done) issued_q <= 1'b0;
      case (st_q)
        ST_IDLE, ST_RUN: if (!hrel_s) begin
          st_q <= ST_START; tries_q <= '0; nack_q <= 1'b0; done_q <= 1'b0; issued_q <= 1'b0;
        end
        ST_HOLD: if (hrel_s) st_q <= ST_RUN;
        ST_START: if (eng_done) begin
          st_q <= ST_WBIT; byte_q <= '0; bit_cnt_q <= '0;
        end
        ST_RSTART: if (eng_done) begin
          st_q <= ST_WBIT; bit_cnt_q <= '0;
        end
        ST_WBIT: if (eng_done) begin
          if (bit_cnt_q == 3'd7) st_q <= ST_WACK;
          else bit_cnt_q <= bit_cnt_q + 3'd1;
        end
        ST_WACK: if (eng_done) begin
          bit_cnt_q <= '0;
          if (eng_bit) begin
            nack_q <= 1'b1; st_q <= ST_STOP;
          end else if (byte_q == BI_W'(2)) begin
            byte_q <= BI_W'(3); st_q <= ST_RSTART;
          end else if (byte_q == BI_W'(3)) begin
            byte_q <= '0; st_q <= ST_RBIT;
          end else begin
            byte_q <= byte_q + 1'b1; st_q <= ST_WBIT;
          end
        end
        ST_RBIT: if (eng_done) begin
          shift_q <= {shift_q[2*WORD_W-2:0], eng_bit};
          if (bit_cnt_q == 3'd7) st_q <= ST_RACK;
          else bit_cnt_q <= bit_cnt_q + 3'd1;
        end
        ST_RACK: if (eng_done) begin
          bit_cnt_q <= '0;
          if (last_rd) st_q <= ST_STOP;
          else begin byte_q <= byte_q + 1'b1; st_q <= ST_RBIT; end
        end
        ST_STOP: if (eng_done) begin
          if (nack_q && tries_q != TRY_W'(MAX_RETRY)) begin
            tries_q <= tries_q + 1'b1; nack_q <= 1'b0; st_q <= ST_START;
          end else begin
            st_q <= ST_HOLD; done_q <= 1'b1;
            lo_q <= nack_q ? DEF_LO : shift_q[2*WORD_W-1:WORD_W];
            hi_q <= nack_q ? DEF_HI : shift_q[WORD_W-1:0];
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg_lo_o   = lo_q;
  assign cfg_hi_o   = hi_q;
  assign done_o     = done_q;
  assign i2c_hold_o = ~hrel_s;
  assign boot_en_o  = (st_q == ST_RUN) && hi_q[BOOT_BIT];
endmodule

// File: rtl/cwl_checker.sv
module cwl_checker #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hrel_i,
  input logic              done_i,
  input logic              boot_en_i,
  input logic              scl_oe_i,
  input logic              sda_oe_i,
  input logic [WORD_W-1:0] cfg_lo_i,
  input logic [WORD_W-1:0] cfg_hi_i
);
  a_r5_words_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && $past(done_i)) |-> ($stable(cfg_lo_i) && $stable(cfg_hi_i)));

  a_r5_bus_free_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (!scl_oe_i && !sda_oe_i));

  a_r10_release_on_negate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hrel_i |=> (!scl_oe_i && !sda_oe_i));

  a_r8_boot_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_en_i |-> done_i);

  a_r8_boot_off_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hrel_i && !$past(hrel_i)) |-> !boot_en_i);
endmodule

bind cfg_word_loader cwl_checker #(.WORD_W(WORD_W)) u_cwl_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hrel_i(hrel_s), .done_i(done_o),
  .boot_en_i(boot_en_o), .scl_oe_i(scl_oe_o), .sda_oe_i(sda_oe_o),
  .cfg_lo_i(cfg_lo_o), .cfg_hi_i(cfg_hi_o)
);

// File: tb/cfg_word_loader_bench.sv
module cfg_word_loader_bench;
  localparam int DIV = 4;
  localparam logic [6:0]  ADDR  = 7'h50;
  localparam logic [31:0] D_LO  = 32'h0000_A0E1;
  localparam logic [31:0] D_HI  = 32'h4C00_0010;
  localparam int BOOT = 5;

  logic clk = 1'b0, rst_ni = 1'b0, hreset_ni = 1'b1;
  logic scl_oe, sda_oe, done, hold, boot;
  logic [31:0] lo, hi;
  logic slv_low = 1'b0;
  logic scl_w, sda_w;
  assign scl_w = ~scl_oe;
  assign sda_w = ~(sda_oe | slv_low);

  always #10 clk = ~clk;

  cfg_word_loader #(.CLK_DIV(DIV)) u_cfg_word_loader (
    .clk_i(clk), .rst_ni(rst_ni), .hreset_ni(hreset_ni), .sda_i(sda_w),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .cfg_lo_o(lo), .cfg_hi_o(hi),
    .done_o(done), .i2c_hold_o(hold), .boot_en_o(boot)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(negedge clk) cyc++;

  // memory model
  logic [7:0]  mem [8];
  logic [7:0]  sh;
  logic [15:0] ptr;
  int mode = 0, cnt = 0, nack_left = 0;
  int addr_bytes = 0, tx_bytes = 0, start_cnt = 0, hi_bad = 0, hi_t0 = 0;
  logic first = 1'b0, rd_pend = 1'b0, last_mack = 1'b0, hi_v = 1'b0;

  always @(negedge sda_w) if (scl_w === 1'b1) begin
    start_cnt++; mode = 1; cnt = 0; first = 1'b1; rd_pend = 1'b0; slv_low = 1'b0;
  end
  always @(posedge sda_w) if (scl_w === 1'b1) begin
    mode = 0; hi_v = 1'b0;
  end
  always @(posedge scl_w) begin
    hi_t0 = cyc; hi_v = 1'b1;
    if (mode == 1 && cnt < 8) begin sh = {sh[6:0], sda_w}; cnt++; end
    else if (mode == 2 && cnt == 8) last_mack = sda_w;
  end
  always @(negedge scl_w) begin
    if (hi_v && (cyc - hi_t0) != 2*DIV) hi_bad++;
    hi_v = 1'b0;
    if (mode == 1) begin
      if (cnt == 8) begin
        cnt = 9;
        if (first) begin
          addr_bytes++; first = 1'b0;
          if (sh[7:1] == ADDR && nack_left == 0) begin slv_low = 1'b1; rd_pend = sh[0]; end
          else begin if (sh[7:1] == ADDR) nack_left--; mode = 0; end
        end else begin ptr = {ptr[7:0], sh}; slv_low = 1'b1; end
      end else if (cnt == 9) begin
        slv_low = 1'b0; cnt = 0;
        if (rd_pend) begin mode = 2; rd_pend = 1'b0; slv_low = ~mem[ptr[2:0]][7]; end
      end
    end else if (mode == 2) begin
      if (cnt < 7) begin cnt++; slv_low = ~mem[ptr[2:0]][7-cnt]; end
      else if (cnt == 7) begin cnt = 8; slv_low = 1'b0; end
      else begin
        tx_bytes++;
        if (last_mack) mode = 0;
        else begin ptr++; cnt = 0; slv_low = ~mem[ptr[2:0]][7]; end
      end
    end
  end

  function automatic logic [63:0] exp_words(int nacks);
    if (nacks > 3) return {D_LO, D_HI};
    return {mem[0], mem[1], mem[2], mem[3], mem[4], mem[5], mem[6], mem[7]};
  endfunction

  function automatic int exp_addr_bytes(int nacks);
    return (nacks > 3) ? 4 : nacks + 2;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic wait_done(input int lim);
    int k;
    k = 0;
    while (!done && k < lim) begin @(negedge clk); k++; end
  endtask

  // one full load; force_boot: -1 random, else value of boot bit
  task automatic do_load(input int nacks, input int force_boot);
    logic [63:0] ew;
    for (int i = 0; i < 8; i++) mem[i] = 8'($urandom);
    if (force_boot >= 0) mem[7][BOOT] = force_boot[0];
    nack_left = nacks; addr_bytes = 0; tx_bytes = 0; last_mack = 1'b0; hi_bad = 0;
    @(negedge clk) hreset_ni = 1'b0;
    cycles(6);
    chk("R11 done clears on reassert", 64'(done), 64'd0);
    wait_done(20000);
    ew = exp_words(nacks);
    chk("R5 done raised", 64'(done), 64'd1);
    chk("R4/R6 low word", 64'(lo), 64'(ew[63:32]));
    chk("R4/R6 high word", 64'(hi), 64'(ew[31:0]));
    chk("R6 address bytes seen", 64'(addr_bytes), 64'(exp_addr_bytes(nacks)));
    if (nacks <= 3) begin
      chk("R3 bytes read", 64'(tx_bytes), 64'd8);
      chk("R3 last byte nacked", 64'(last_mack), 64'd1);
      chk("R12 scl high width", 64'(hi_bad), 64'd0);
    end
    cycles(20);
    chk("R5 bus released", {62'd0, scl_oe, sda_oe}, 64'd0);
    chk("R5 words steady", {lo, hi}, ew);
    chk("R7 hold during reset", 64'(hold), 64'd1);
    chk("R8 boot off during reset", 64'(boot), 64'd0);
    @(negedge clk) hreset_ni = 1'b1;
    cycles(4);
    chk("R7 hold released", 64'(hold), 64'd0);
    chk("R8/R9 boot follows field", 64'(boot), 64'(ew[BOOT]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    cycles(5);
    rst_ni = 1'b1;
    cycles(1);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 words", {lo, hi}, {D_LO, D_HI});
    chk("R1 boot/hold", {62'd0, boot, hold}, 64'd0);
    chk("R1 bus", {62'd0, scl_oe, sda_oe}, 64'd0);
    cycles(200);
    chk("R2 no START while released", 64'(start_cnt), 64'd0);
    chk("R2 still idle", 64'(done), 64'd0);

    do_load(0, 1);
    do_load(0, 0);
    do_load(3, 1);
    do_load(4, 1);
    do_load(5, -1);
    for (int i = 0; i < 12; i++) do_load(int'($urandom % 6), -1);

    // abort mid-transfer
    nack_left = 0;
    @(negedge clk) hreset_ni = 1'b0;
    cycles(300);
    chk("R10 busy before abort", 64'(done), 64'd0);
    @(negedge clk) hreset_ni = 1'b1;
    cycles(5);
    chk("R10 done after abort", 64'(done), 64'd1);
    chk("R10 default words", {lo, hi}, {D_LO, D_HI});
    chk("R10 bus released", {62'd0, scl_oe, sda_oe}, 64'd0);
    chk("R9 boot off with defaults", 64'(boot), 64'd0);
    mode = 0; slv_low = 1'b0;
    cycles(5);

    do_load(0, 1);
    finish_run();
  end
endmodule